// File: doc/BRIEF.md
# MDIO Management Master

This block is a register-driven management master for the two-wire MDIO bus that configures Ethernet PHYs. Software writes four 32-bit registers through a simple word-addressed port. The registers hold configuration and status, control, data and address. The block turns some of those writes into serial management frames. It produces the MDC clock from the system clock through a programmable divider. The bidirectional MDIO pin appears as three separate signals: a driven value, an output enable and a sampled input. The open-drain pad is left to the board level.

One shift engine carries every frame. The engine sends an optional 32-bit preamble of ones and then a 32-bit body. The body holds the start code, the opcode, the port address, the register or device address, the turnaround bits and 16 data bits. Bit 6 of the configuration register chooses between the older short-address frame style and the extended style. In the extended style, the register number goes out first in its own address frame. Software watches the busy flag and then collects read data from the data register.

Top module: `mdio_master`

## Requirements
- R1: After reset, every register reads back zero, MDC is low and the output enable is low.
- R2: Configuration bits 15:8 hold the divider D. MDC has a half-period of max(D,1)*2 system clocks. MDC toggles only while a frame runs and rests low otherwise.
- R3: A frame begins with 32 ones. Control bit 10 removes them, so only the 32-bit body is sent.
- R4: With configuration bit 6 clear, the body is start 01, then opcode 01 for a write or 10 for a read. Next come the port address from control bits 9:5 and the register address from control bits 4:0. A write puts turnaround 10 and then 16 data bits, MSB first.
- R5: With configuration bit 6 set, start is 00. Writing the address register (word 3) sends opcode 00 with the written 16-bit number as data. A write frame uses opcode 01 and a read frame uses opcode 11.
- R6: Writing the data register (word 2) sends a write frame carrying bits 15:0 of the written value.
- R7: Writing the control register (word 1) with bit 15 set sends a read frame. The first turnaround bit is driven as 1. The output enable is low from the second turnaround bit through the last data bit. The 16 bits sampled on MDC rising edges, MSB first, can then be read from data bits 15:0.
- R8: Configuration bit 1 is set when MDIO is high at the rising edge in the second turnaround bit of a read. It is cleared when the next read starts.
- R9: Busy shows in configuration bit 0 and in data bit 31. It is set from the write that launches a frame until that frame's last MDC falling edge.
- R10: A write that would start a frame while busy is ignored: no frame is sent and the data register keeps its value.
- R11: Writing the address register while configuration bit 6 is clear starts no frame.
- R12: The read port is registered. The word chosen by the 2-bit address shows on the read data one clock later.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst | input | 1 | Synchronous active-high reset |
| reg_wr | input | 1 | Register write strobe |
| reg_addr | input | 2 | Word select: 0 config/status, 1 control, 2 data, 3 address |
| reg_wdata | input | 32 | Write data |
| reg_rdata | output | 32 | Registered read data for reg_addr |
| mdc | output | 1 | Management clock |
| mdio_o | output | 1 | Value driven onto MDIO |
| mdio_oe | output | 1 | MDIO output enable |
| mdio_i | input | 1 | Value sampled from MDIO |

## Verification
The assertions check the following on every cycle:
- MDC rests low whenever no frame runs.
- The output enable is low when idle.
- The line stays released through the data bits of a read.
- Busy rises only after a register write and falls only on an MDC falling edge.
- A data write during a non-read frame leaves the data register unchanged.

Some behaviour only the bench scenarios can show. These are the exact bit order of each frame type, the preamble choice, and the measured MDC period for several divider values. The bench scenarios also show the read capture and the turnaround error. A small PHY model on the bench side answers reads.

// File: rtl/mdio_pkg.sv
package mdio_pkg;
  typedef enum logic [1:0] {
    REG_CFG  = 2'd0,
    REG_CTL  = 2'd1,
    REG_DATA = 2'd2,
    REG_ADDR = 2'd3
  } reg_sel_e;

  localparam int DATA_BITS     = 16;
  localparam int BODY_BITS     = 32;
  localparam int PREAMBLE_BITS = 32;
  localparam int FRAME_BITS    = BODY_BITS + PREAMBLE_BITS;

  localparam int CFG_BUSY_BIT = 0;
  localparam int CFG_ERR_BIT  = 1;
  localparam int CFG_EXT_BIT  = 6;
  localparam int CTL_NOPRE    = 10;
  localparam int CTL_READ     = 15;
endpackage

// File: rtl/mdio_clk_gen.sv
module mdio_clk_gen #(
  parameter int DIV_W = 8
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             run,
  input  logic [DIV_W-1:0] div,
  output logic             mdc,
  output logic             rise_tick,
  output logic             fall_tick
);
  localparam int CNT_W = DIV_W + 1;

  logic [CNT_W-1:0] cnt;
  logic [CNT_W-1:0] half;
  logic             term;

  always_comb begin
    half = (div == '0) ? CNT_W'(2) : {div, 1'b0};
    term = (cnt >= half - CNT_W'(1));
  end

  assign rise_tick = run && term && !mdc;
  assign fall_tick = run && term && mdc;

  always_ff @(posedge clk) begin
    if (rst || !run) begin
      cnt <= '0;
      mdc <= 1'b0;
    end else if (term) begin
      cnt <= '0;
      mdc <= ~mdc;
    end else begin
      cnt <= cnt + CNT_W'(1);
    end
  end

  assert_mdc_idle_low_R2: assert property (@(posedge clk) disable iff (rst)
    !run |=> !mdc);
endmodule

// File: rtl/mdio_frame_engine.sv
module mdio_frame_engine #(
  parameter  int FRAME_W = 64,
  parameter  int DATA_W  = 16,
  localparam int CW      = $clog2(FRAME_W + 1)
) (
  input  logic               clk,
  input  logic               rst,
  input  logic               start,
  input  logic [FRAME_W-1:0] frame,
  input  logic [CW-1:0]      len,
  input  logic               is_read,
  input  logic               rise,
  input  logic               fall,
  input  logic               mdio_i,
  output logic               busy,
  output logic               mdio_o,
  output logic               mdio_oe,
  output logic               rd_err,
  output logic [DATA_W-1:0]  rd_data,
  output logic               rd_done
);
  localparam logic [CW-1:0] LEFT_TA2  = CW'(DATA_W + 1);
  localparam logic [CW-1:0] LEFT_DATA = CW'(DATA_W);

  logic [FRAME_W-1:0] sh;
  logic [CW-1:0]      cnt;
  logic               rd_q;
  logic [CW-1:0]      cnt_nx;

  assign cnt_nx  = cnt - CW'(1);
  assign rd_done = busy && fall && rd_q && (cnt == CW'(1));

  always_ff @(posedge clk) begin
    if (rst) begin
      busy    <= 1'b0;
      sh      <= '0;
      cnt     <= '0;
      rd_q    <= 1'b0;
      mdio_o  <= 1'b1;
      mdio_oe <= 1'b0;
      rd_err  <= 1'b0;
      rd_data <= '0;
    end else if (!busy) begin
      if (start) begin
        busy    <= 1'b1;
        sh      <= frame;
        cnt     <= len;
        rd_q    <= is_read;
        mdio_o  <= frame[FRAME_W-1];
        mdio_oe <= 1'b1;
        if (is_read) rd_err <= 1'b0;
      end
    end else begin
      if (rise && rd_q) begin
        if (cnt == LEFT_TA2) rd_err <= mdio_i;
        if (cnt <= LEFT_DATA) rd_data <= {rd_data[DATA_W-2:0], mdio_i};
      end
      if (fall) begin
        if (cnt == CW'(1)) begin
          busy    <= 1'b0;
          mdio_o  <= 1'b1;
          mdio_oe <= 1'b0;
        end else begin
          sh      <= sh << 1;
          mdio_o  <= sh[FRAME_W-2];
          cnt     <= cnt_nx;
          mdio_oe <= !(rd_q && (cnt_nx <= LEFT_TA2));
        end
      end
    end
  end

  assert_idle_released_R9: assert property (@(posedge clk) disable iff (rst)
    !busy |-> !mdio_oe);
  assert_read_data_released_R7: assert property (@(posedge clk) disable iff (rst)
    (busy && rd_q && (cnt <= LEFT_DATA)) |-> !mdio_oe);
  assert_end_on_fall_R9: assert property (@(posedge clk) disable iff (rst)
    $fell(busy) |-> $past(fall));
endmodule

// File: rtl/mdio_master.sv
module mdio_master #(
  parameter int DIV_W = 8
) (
  input  logic        clk,
  input  logic        rst,
  input  logic        reg_wr,
  input  logic [1:0]  reg_addr,
  input  logic [31:0] reg_wdata,
  output logic [31:0] reg_rdata,
  output logic        mdc,
  output logic        mdio_o,
  output logic        mdio_oe,
  input  logic        mdio_i
);
  import mdio_pkg::*;

  localparam int CW = $clog2(FRAME_BITS + 1);

  logic             ext_q;
  logic [DIV_W-1:0] div_q;
  logic [10:0]      ctl_q;
  logic [15:0]      data_q;
  logic [15:0]      addr_q;

  logic busy, rd_err, rd_done, rise, fall;
  logic [DATA_BITS-1:0] rd_data;

  logic go_rd, go_wr, go_ad, start;
  logic [10:0] ctl_eff;
  logic [1:0]  op, st, ta;
  logic [15:0] payload;
  logic [BODY_BITS-1:0]  body;
  logic [FRAME_BITS-1:0] frame;
  logic [CW-1:0]         len;

  logic unused_wdata;
  assign unused_wdata = ^{reg_wdata[31:16], reg_wdata[14:11], reg_wdata[7]};

  always_comb begin
    go_rd   = reg_wr && (reg_addr == REG_CTL) && reg_wdata[CTL_READ];
    go_wr   = reg_wr && (reg_addr == REG_DATA);
    go_ad   = reg_wr && (reg_addr == REG_ADDR) && ext_q;
    start   = !busy && (go_rd || go_wr || go_ad);
    ctl_eff = (reg_addr == REG_CTL) ? reg_wdata[10:0] : ctl_q;
    st      = ext_q ? 2'b00 : 2'b01;
    if (ext_q) op = go_ad ? 2'b00 : (go_rd ? 2'b11 : 2'b01);
    else       op = go_rd ? 2'b10 : 2'b01;
    ta      = go_rd ? 2'b11 : 2'b10;
    payload = go_rd ? 16'hFFFF : reg_wdata[15:0];
    body    = {st, op, ctl_eff[9:5], ctl_eff[4:0], ta, payload};
    frame   = ctl_eff[CTL_NOPRE] ? {body, {PREAMBLE_BITS{1'b1}}}
                                 : {{PREAMBLE_BITS{1'b1}}, body};
    len     = ctl_eff[CTL_NOPRE] ? CW'(BODY_BITS) : CW'(FRAME_BITS);
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      ext_q  <= 1'b0;
      div_q  <= '0;
      ctl_q  <= '0;
      data_q <= '0;
      addr_q <= '0;
    end else begin
      if (rd_done) data_q <= rd_data;
      if (reg_wr) begin
        case (reg_addr)
          REG_CFG: begin
            ext_q <= reg_wdata[CFG_EXT_BIT];
            div_q <= reg_wdata[8 +: DIV_W];
          end
          REG_CTL:  if (!(busy && reg_wdata[CTL_READ])) ctl_q <= reg_wdata[10:0];
          REG_DATA: if (!busy) data_q <= reg_wdata[15:0];
          default:  if (!(busy && ext_q)) addr_q <= reg_wdata[15:0];
        endcase
      end
    end
  end

  always_ff @(posedge clk) begin
    if (rst) reg_rdata <= '0;
    else begin
      case (reg_addr)
        REG_CFG:  reg_rdata <= {16'd0, div_q, 1'b0, ext_q, 4'd0, rd_err, busy};
        REG_CTL:  reg_rdata <= {21'd0, ctl_q};
        REG_DATA: reg_rdata <= {busy, 15'd0, data_q};
        default:  reg_rdata <= {16'd0, addr_q};
      endcase
    end
  end

  mdio_clk_gen #(.DIV_W(DIV_W)) u_clk (
    .clk(clk), .rst(rst), .run(busy), .div(div_q),
    .mdc(mdc), .rise_tick(rise), .fall_tick(fall)
  );

  mdio_frame_engine #(.FRAME_W(FRAME_BITS), .DATA_W(DATA_BITS)) u_eng (
    .clk(clk), .rst(rst), .start(start), .frame(frame), .len(len),
    .is_read(go_rd), .rise(rise), .fall(fall), .mdio_i(mdio_i),
    .busy(busy), .mdio_o(mdio_o), .mdio_oe(mdio_oe), .rd_err(rd_err),
    .rd_data(rd_data), .rd_done(rd_done)
  );

  assert_launch_by_write_R9: assert property (@(posedge clk) disable iff (rst)
    $rose(busy) |-> $past(reg_wr));
  assert_busy_data_kept_R10: assert property (@(posedge clk) disable iff (rst)
    (busy && !rd_done && reg_wr && (reg_addr == REG_DATA)) |=> $stable(data_q));
endmodule

// File: tb/mdio_master_bench.sv
module mdio_master_bench;
  logic        clk = 1'b0;
  logic        rst = 1'b1;
  logic        reg_wr = 1'b0;
  logic [1:0]  reg_addr = 2'd0;
  logic [31:0] reg_wdata = '0;
  logic [31:0] reg_rdata;
  logic        mdc, mdio_o, mdio_oe, mdio_i;

  int tests = 0;
  int fails = 0;
  int nbits = 0;
  int phy_len = 0;
  logic [63:0] phy_vec = '0;
  logic [63:0] cap_o = '0;
  logic [63:0] cap_oe = '0;
  int cyc = 0;
  int rise_t [2];

  always #5 clk = ~clk;

  mdio_master u_mdio_master (
    .clk(clk), .rst(rst), .reg_wr(reg_wr), .reg_addr(reg_addr),
    .reg_wdata(reg_wdata), .reg_rdata(reg_rdata), .mdc(mdc),
    .mdio_o(mdio_o), .mdio_oe(mdio_oe), .mdio_i(mdio_i)
  );

  assign mdio_i = (nbits < phy_len) ? phy_vec[phy_len-1-nbits] : 1'b1;

  always @(posedge clk) cyc <= cyc + 1;

  always @(posedge mdc) begin
    cap_o  = {cap_o[62:0], mdio_o};
    cap_oe = {cap_oe[62:0], mdio_oe};
    rise_t[0] = rise_t[1];
    rise_t[1] = cyc;
    nbits = nbits + 1;
  end

  task automatic chk(input string req, input logic [63:0] act, input logic [63:0] exp);
    tests++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  task automatic wr(input logic [1:0] a, input logic [31:0] d);
    @(negedge clk);
    reg_wr = 1'b1; reg_addr = a; reg_wdata = d;
    @(negedge clk);
    reg_wr = 1'b0;
  endtask

  task automatic rd(input logic [1:0] a, output logic [31:0] d);
    @(negedge clk);
    reg_addr = a;
    @(negedge clk);
    d = reg_rdata;
  endtask

  task automatic arm(input logic [63:0] v, input int l);
    nbits = 0; cap_o = '0; cap_oe = '0; phy_vec = v; phy_len = l;
  endtask

  task automatic wait_idle();
    logic [31:0] s;
    for (int i = 0; i < 5000; i++) begin
      rd(2'd0, s);
      if (!s[0]) break;
    end
  endtask

  function automatic logic [31:0] body(input logic [1:0] st, input logic [1:0] op,
      input logic [4:0] pa, input logic [4:0] ra, input logic [1:0] ta,
      input logic [15:0] d);
    return {st, op, pa, ra, ta, d};
  endfunction

  task automatic t_reset();
    logic [31:0] v;
    for (int a = 0; a < 4; a++) begin
      rd(2'(a), v);
      chk("R1 register reset", 64'(v), 64'd0);
    end
    chk("R1 mdc/oe reset", {62'd0, mdc, mdio_oe}, 64'd0);
    rd(2'd0, v);
    chk("R12 registered read", 64'(v), 64'd0);
  endtask

  task automatic t_c22_write();
    logic [31:0] v;
    wr(2'd0, 32'h0000_0100);
    wr(2'd1, {21'd0, 1'b0, 5'd9, 5'd3});
    arm('0, 0);
    wr(2'd2, 32'h0000_A5C3);
    rd(2'd2, v);
    chk("R9 busy in data bit31", 64'(v[31]), 64'd1);
    rd(2'd0, v);
    chk("R9 busy in config bit0", 64'(v[0]), 64'd1);
    wait_idle();
    chk("R3 preamble bit count", 64'(nbits), 64'd64);
    chk("R4 R6 short write frame", cap_o,
        {32'hFFFF_FFFF, body(2'b01, 2'b01, 5'd9, 5'd3, 2'b10, 16'hA5C3)});
    chk("R4 driven throughout write", cap_oe, {64{1'b1}});
    rd(2'd2, v);
    chk("R6 data readback", 64'(v), 64'h0000_A5C3);
  endtask

  task automatic t_c22_read();
    logic [31:0] v;
    wr(2'd1, {21'd0, 1'b1, 5'd4, 5'd17});
    arm({32'd0, 15'h7FFF, 1'b0, 16'hBEEF}, 32);
    wr(2'd1, {16'd0, 1'b1, 4'd0, 1'b1, 5'd4, 5'd17});
    wait_idle();
    chk("R3 no preamble bit count", 64'(nbits), 64'd32);
    chk("R4 short read header", 64'(cap_o[31:17]),
        64'(body(2'b01, 2'b10, 5'd4, 5'd17, 2'b11, 16'hFFFF) >> 17));
    chk("R7 oe pattern", 64'(cap_oe[31:0]), 64'hFFFE_0000);
    rd(2'd2, v);
    chk("R7 read data", 64'(v), 64'h0000_BEEF);
    rd(2'd0, v);
    chk("R8 no error on good turnaround", 64'(v[1]), 64'd0);
    rd(2'd1, v);
    chk("R7 read bit not stored", 64'(v[15]), 64'd0);
  endtask

  task automatic t_read_error();
    logic [31:0] v;
    arm('0, 0);
    wr(2'd1, {16'd0, 1'b1, 4'd0, 1'b1, 5'd1, 5'd2});
    wait_idle();
    rd(2'd0, v);
    chk("R8 error set", 64'(v[1]), 64'd1);
    rd(2'd2, v);
    chk("R8 data when nothing answers", 64'(v[15:0]), 64'hFFFF);
    arm({32'd0, 15'h7FFF, 1'b0, 16'h0123}, 32);
    wr(2'd1, {16'd0, 1'b1, 4'd0, 1'b1, 5'd1, 5'd2});
    wait_idle();
    rd(2'd0, v);
    chk("R8 error cleared by next read", 64'(v[1]), 64'd0);
  endtask

  task automatic t_c45();
    logic [31:0] v;
    wr(2'd0, 32'h0000_0140);
    wr(2'd1, {21'd0, 1'b1, 5'd30, 5'd7});
    arm('0, 0);
    wr(2'd3, 32'h0000_1F2E);
    wait_idle();
    chk("R5 address frame", 64'(cap_o[31:0]),
        64'(body(2'b00, 2'b00, 5'd30, 5'd7, 2'b10, 16'h1F2E)));
    arm('0, 0);
    wr(2'd2, 32'h0000_0F0F);
    wait_idle();
    chk("R5 extended write frame", 64'(cap_o[31:0]),
        64'(body(2'b00, 2'b01, 5'd30, 5'd7, 2'b10, 16'h0F0F)));
    arm({32'd0, 15'h7FFF, 1'b0, 16'h6789}, 32);
    wr(2'd1, {16'd0, 1'b1, 4'd0, 1'b1, 5'd30, 5'd7});
    wait_idle();
    chk("R5 extended read header", 64'(cap_o[31:17]),
        64'(body(2'b00, 2'b11, 5'd30, 5'd7, 2'b11, 16'hFFFF) >> 17));
    rd(2'd2, v);
    chk("R5 extended read data", 64'(v), 64'h0000_6789);
  endtask

  task automatic t_busy_ignore();
    logic [31:0] v;
    wr(2'd0, 32'h0000_0100);
    wr(2'd1, {21'd0, 1'b1, 5'd2, 5'd5});
    arm('0, 0);
    wr(2'd2, 32'h0000_1234);
    wr(2'd2, 32'h0000_5555);
    wr(2'd1, {16'd0, 1'b1, 4'd0, 1'b1, 5'd2, 5'd5});
    wait_idle();
    repeat (20) @(negedge clk);
    chk("R10 single frame sent", 64'(nbits), 64'd32);
    chk("R10 frame content kept", 64'(cap_o[31:0]),
        64'(body(2'b01, 2'b01, 5'd2, 5'd5, 2'b10, 16'h1234)));
    rd(2'd2, v);
    chk("R10 data unchanged", 64'(v), 64'h0000_1234);
  endtask

  task automatic t_addr_no_ext();
    logic [31:0] v;
    arm('0, 0);
    wr(2'd3, 32'h0000_4444);
    repeat (30) @(negedge clk);
    chk("R11 no frame", 64'(nbits), 64'd0);
    rd(2'd0, v);
    chk("R11 not busy", 64'(v[0]), 64'd0);
  endtask

  task automatic t_mdc_period(input logic [7:0] d, input int half);
    wr(2'd0, {16'd0, d, 8'd0});
    arm('0, 0);
    wr(2'd2, 32'h0000_0000);
    wait_idle();
    chk("R2 mdc period", 64'(rise_t[1] - rise_t[0]), 64'(2 * half));
    chk("R2 mdc low when idle", 64'(mdc), 64'd0);
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    fails++;
    $display("FAIL watchdog expired");
    $display("[TB] %0d tests run, %0d failed", tests, fails);
    $finish;
  end

  initial begin
    repeat (3) @(negedge clk);
    rst = 1'b0;
    t_reset();
    t_c22_write();
    t_c22_read();
    t_read_error();
    t_c45();
    wr(2'd0, 32'h0000_0100);
    t_busy_ignore();
    t_addr_no_ext();
    t_mdc_period(8'd3, 6);
    t_mdc_period(8'd0, 2);
    t_mdc_period(8'd1, 2);
    $display("[TB] %0d tests run, %0d failed", tests, fails);
    $finish;
  end
endmodule